// File: doc/BRIEF.md
# Programmable Up/Down Pulse Counter Channel

This block is a single counting channel for a pulse or flow-meter input card. A 16-bit control word configures it. It counts rising edges of a single-ended pulse input, or the legal 4x transitions of a quadrature A/B pair. The count width is 16 or 24 bits and wraps modulo the selected size. All inputs arrive already synchronized to `clk`.

The control word can also:
- hold the count at a preset value,
- force the count and all flags to zero,
- qualify counting with an external gate,
- choose or invert the count direction,
- clear the sticky flags on their own.

Three sticky flags record events seen since the last clear: a wrap past the full range, a move away from a programmable limit value, and a result of zero. The flags are packed into a small status word next to the count output.

Top module: `pcc_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `count_out` is 0 and `status_out` is 0.
- R2: While `ctrl_word[15]` is 1 (and bit 14 is 0), each clock loads `preset_val` (masked to the selected size) into the count, and count events are ignored. Counting resumes on the first edge after bit 15 returns to 0.
- R3: When `ctrl_word[14]` is 1, the next clock edge sets the count to 0 and clears all three flags. This takes priority over preset, count events and flag setting.
- R4: With `ctrl_word[13]` = 1, a count event takes effect only when `gate_in` is 1 in that cycle. With bit 13 = 0, `gate_in` has no effect.
- R5: With `ctrl_word[8]` = 0 (single-pulse mode), each 0-to-1 change of `pulse_in` between consecutive clock edges is one event. `ctrl_word[12]` = 0 counts up and 1 counts down. The count changes on the same edge that samples the new high level.
- R6: With `ctrl_word[8]` = 1 (quadrature mode), the forward sequence of {`quad_a`,`quad_b`} is 00→10→11→01→00.
  - A one-step move forward counts up and a one-step move backward counts down.
  - `ctrl_word[12]` = 1 swaps these two directions.
  - No change, or a change of both inputs at once, is not an event.
- R7: `ctrl_word[9]` = 0 selects 16-bit counting (modulo 65,536, `count_out[23:16]` reads 0). `ctrl_word[9]` = 1 selects 24-bit counting (modulo 16,777,216).
- R8: The max flag (status bit 2) sets on an event that wraps the count: up from the all-ones value of the selected size, or down from 0.
- R9: The limit flag (status bit 1) sets on an event whose starting count equals `limit_val` masked to the selected size.
- R10: The zero flag (status bit 0) sets on an event whose resulting count is 0.
- R11: `ctrl_word[11]` = 1 clears the three flags at the next edge and leaves the count unchanged. A flag whose event occurs in that same cycle ends set.
- R12: Flags stay set until bit 11 or bit 14 clears them. `status_out[7:3]` always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 16 | Control word (bits 15,14,13,12,11,9,8 used) |
| preset_val | input | 24 | Value loaded while preset is held |
| limit_val | input | 24 | Limit compared against the count |
| pulse_in | input | 1 | Single-ended pulse input |
| quad_a | input | 1 | Quadrature phase A |
| quad_b | input | 1 | Quadrature phase B |
| gate_in | input | 1 | External gate qualifying count events |
| count_out | output | 24 | Current count, masked to the selected size |
| status_out | output | 8 | Flags: bit 0 zero, bit 1 limit, bit 2 max, rest 0 |

## Verification
A flag-clear request and a flag-setting count event can occur in the same cycle, and so can a count event and a clear or preset command. The random phase raises bit 11 on about one cycle in sixteen while pulses and quadrature steps keep arriving, so these collisions occur many times. Limit values are kept small so that the count's random walk crosses them often. Each cycle the count and status are compared with a bench model that applies the stated priorities: clear over preset over counting, and flag setting over a soft flag clear. Directed steps cover the wrap at both sizes, the held preset, the gate and the quadrature inversion.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int unsigned PCC_CNT_W  = 24;
  localparam int unsigned PCC_STD_W  = 16;
  localparam int unsigned PCC_CTRL_W = 16;
  localparam int unsigned PCC_STAT_W = 8;

  // control word bit positions
  localparam int unsigned CB_PRESET  = 15;
  localparam int unsigned CB_CLEAR   = 14;
  localparam int unsigned CB_GATE    = 13;
  localparam int unsigned CB_DIR     = 12;
  localparam int unsigned CB_FLAGCLR = 11;
  localparam int unsigned CB_WIDE    = 9;
  localparam int unsigned CB_QUAD    = 8;

  // flag positions inside the status word
  localparam int unsigned FLAG_N  = 3;
  localparam int unsigned FB_ZERO = 0;
  localparam int unsigned FB_LIM  = 1;
  localparam int unsigned FB_MAX  = 2;

  typedef struct packed {
    logic fire;
    logic up;
  } step_t;

  // 4x decode of one quadrature transition; forward order of {A,B}: 00,10,11,01
  function automatic step_t quad_step(input logic [1:0] prev, input logic [1:0] cur);
    step_t s;
    s.fire = 1'b0;
    s.up   = 1'b0;
    case ({prev, cur})
      4'b0010, 4'b1011, 4'b1101, 4'b0100: begin s.fire = 1'b1; s.up = 1'b1; end
      4'b0001, 4'b0111, 4'b1110, 4'b1000: begin s.fire = 1'b1; s.up = 1'b0; end
      default: ;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/pcc_event_gen.sv
module pcc_event_gen
  import pcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic quad_mode,
  input  logic dir_inv,
  input  logic gate_en,
  input  logic gate_in,
  input  logic pulse_in,
  input  logic quad_a,
  input  logic quad_b,
  output logic evt_fire,
  output logic evt_up
);
  logic       pulse_q;
  logic [1:0] ab_q;
  step_t      qs;
  logic       pulse_rise;
  logic       raw_fire;
  logic       raw_up;
  logic       gate_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      ab_q    <= 2'b00;
    end else begin
      pulse_q <= pulse_in;
      ab_q    <= {quad_a, quad_b};
    end
  end

  always_comb begin
    qs         = quad_step(ab_q, {quad_a, quad_b});
    pulse_rise = pulse_in & ~pulse_q;
    if (quad_mode) begin
      raw_fire = qs.fire;
      raw_up   = qs.up ^ dir_inv;
    end else begin
      raw_fire = pulse_rise;
      raw_up   = ~dir_inv;
    end
    gate_open = ~gate_en | gate_in;
    evt_fire  = raw_fire & gate_open;
    evt_up    = raw_up;
  end
endmodule

// File: rtl/pcc_count_core.sv
module pcc_count_core #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned STD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic             wide,
  input  logic             evt_fire,
  input  logic             evt_up,
  input  logic [CNT_W-1:0] preset_val,
  input  logic [CNT_W-1:0] limit_val,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_vis,
  output logic             hit_max,
  output logic             hit_lim,
  output logic             hit_zero
);
  localparam int unsigned EXT_W = CNT_W - STD_W;

  function automatic logic [CNT_W-1:0] mask_of(input logic w);
    return w ? {CNT_W{1'b1}} : {{EXT_W{1'b0}}, {STD_W{1'b1}}};
  endfunction

  function automatic logic [CNT_W-1:0] next_of(input logic [CNT_W-1:0] c,
                                               input logic up,
                                               input logic [CNT_W-1:0] m);
    return up ? ((c + 1'b1) & m) : ((c - 1'b1) & m);
  endfunction

  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cur;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] lim;
  logic             live;

  always_comb begin
    mask      = mask_of(wide);
    cur       = count_q & mask;
    nxt       = next_of(cur, evt_up, mask);
    lim       = limit_val & mask;
    live      = evt_fire & ~clear & ~load;
    hit_max   = live & (evt_up ? (cur == mask) : (cur == '0));
    hit_lim   = live & (cur == lim);
    hit_zero  = live & (nxt == '0);
    count_vis = cur;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     count_q <= '0;
    else if (clear) count_q <= '0;
    else if (load)  count_q <= preset_val & mask;
    else if (live)  count_q <= nxt;
  end
endmodule

// File: rtl/pcc_flag_bank.sv
module pcc_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_all,
  input  logic         clear_soft,
  input  logic [N-1:0] set_hit,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (clear_all)  flag_q[i] <= 1'b0;
      else if (set_hit[i]) flag_q[i] <= 1'b1;
      else if (clear_soft) flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pcc_top.sv
module pcc_top
  import pcc_pkg::*;
#(
  parameter int unsigned CNT_W  = PCC_CNT_W,
  parameter int unsigned STD_W  = PCC_STD_W,
  parameter int unsigned CTRL_W = PCC_CTRL_W,
  parameter int unsigned STAT_W = PCC_STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [CNT_W-1:0]  preset_val,
  input  logic [CNT_W-1:0]  limit_val,
  input  logic              pulse_in,
  input  logic              quad_a,
  input  logic              quad_b,
  input  logic              gate_in,
  output logic [CNT_W-1:0]  count_out,
  output logic [STAT_W-1:0] status_out
);
  logic              evt_fire;
  logic              evt_up;
  logic [CNT_W-1:0]  count_q;
  logic              hit_max;
  logic              hit_lim;
  logic              hit_zero;
  logic [FLAG_N-1:0] set_hit;
  logic [FLAG_N-1:0] flag_q;

  pcc_event_gen u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .quad_mode(ctrl_word[CB_QUAD]),
    .dir_inv  (ctrl_word[CB_DIR]),
    .gate_en  (ctrl_word[CB_GATE]),
    .gate_in  (gate_in),
    .pulse_in (pulse_in),
    .quad_a   (quad_a),
    .quad_b   (quad_b),
    .evt_fire (evt_fire),
    .evt_up   (evt_up)
  );

  pcc_count_core #(.CNT_W(CNT_W), .STD_W(STD_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ctrl_word[CB_CLEAR]),
    .load      (ctrl_word[CB_PRESET]),
    .wide      (ctrl_word[CB_WIDE]),
    .evt_fire  (evt_fire),
    .evt_up    (evt_up),
    .preset_val(preset_val),
    .limit_val (limit_val),
    .count_q   (count_q),
    .count_vis (count_out),
    .hit_max   (hit_max),
    .hit_lim   (hit_lim),
    .hit_zero  (hit_zero)
  );

  always_comb begin
    set_hit           = '0;
    set_hit[FB_MAX]   = hit_max;
    set_hit[FB_LIM]   = hit_lim;
    set_hit[FB_ZERO]  = hit_zero;
  end

  pcc_flag_bank #(.N(FLAG_N)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (ctrl_word[CB_CLEAR]),
    .clear_soft(ctrl_word[CB_FLAGCLR]),
    .set_hit   (set_hit),
    .flag_q    (flag_q)
  );

  for (genvar s = 0; s < STAT_W; s++) begin : g_stat
    if (s < FLAG_N) begin : g_flagbit
      assign status_out[s] = flag_q[s];
    end else begin : g_pad
      assign status_out[s] = 1'b0;
    end
  end
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] ctrl_word,
  input logic [23:0] preset_val,
  input logic        gate_in,
  input logic        evt_fire,
  input logic [23:0] count_q,
  input logic [2:0]  flag_q,
  input logic [7:0]  status_out
);
  logic [23:0] mask_now;
  assign mask_now = ctrl_word[9] ? 24'hFFFFFF : 24'h00FFFF;

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[14] |=> (count_q == '0) && (flag_q == '0)); // R3

  AST_PRESET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[15] && !ctrl_word[14] |=> count_q == ($past(preset_val) & $past(mask_now))); // R2

  AST_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[13] && !gate_in |-> !evt_fire); // R4

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[11] && !ctrl_word[14] |=> (flag_q & $past(flag_q)) == $past(flag_q)); // R12

  AST_SOFTCLR_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[11] && !ctrl_word[14] && !ctrl_word[15] && !evt_fire |=> $stable(count_q)); // R11

  AST_EVENT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fire && !ctrl_word[14] && !ctrl_word[15] |=> count_q != $past(count_q)); // R5

  AST_STATUS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    status_out[7:3] == 5'd0); // R12
endmodule

bind pcc_top pcc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_word (ctrl_word),
  .preset_val(preset_val),
  .gate_in   (gate_in),
  .evt_fire  (evt_fire),
  .count_q   (count_q),
  .flag_q    (flag_q),
  .status_out(status_out)
);

// File: tb/pcc_top_tb_top.sv
`timescale 1ns/1ps
module pcc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ctrl = '0;
  logic [23:0] preset = '0;
  logic [23:0] limit = 24'h000064;
  logic        pulse = 1'b0, qa = 1'b0, qb = 1'b0, gate = 1'b0;
  logic [23:0] count_out;
  logic [7:0]  status_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model state
  logic [23:0] m_cnt = '0;
  logic [2:0]  m_fl = '0;
  logic        m_pp = 1'b0;
  logic [1:0]  m_pab = 2'b00;

  always #2.5 clk = ~clk;

  pcc_top dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl), .preset_val(preset), .limit_val(limit),
    .pulse_in(pulse), .quad_a(qa), .quad_b(qb), .gate_in(gate),
    .count_out(count_out), .status_out(status_out)
  );

  function automatic logic [23:0] bmask(input logic ext);
    return ext ? 24'hFFFFFF : 24'h00FFFF;
  endfunction

  // position along the forward quadrature cycle
  function automatic int qpos(input logic [1:0] ab);
    case (ab)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic model_edge();
    logic ev, up;
    int d;
    logic [23:0] m, old, nw;
    logic [2:0] set;
    ev = 0; up = 0; set = '0;
    m = bmask(ctrl[9]);
    if (!rst_n) begin
      m_cnt = '0; m_fl = '0; m_pp = 0; m_pab = 2'b00;
      return;
    end
    if (!ctrl[8]) begin
      ev = pulse && !m_pp; up = !ctrl[12];
    end else begin
      d = (qpos({qa, qb}) - qpos(m_pab) + 4) % 4;
      ev = (d == 1) || (d == 3);
      up = (d == 1) ^ ctrl[12];
    end
    if (ctrl[13] && !gate) ev = 0;
    m_pp = pulse; m_pab = {qa, qb};
    if (ctrl[14]) begin
      m_cnt = '0; m_fl = '0;
    end else begin
      if (ctrl[15]) m_cnt = preset & m;
      else if (ev) begin
        old = m_cnt & m;
        nw  = up ? ((old + 1) & m) : ((old - 1) & m);
        set[2] = up ? (old == m) : (old == 0);
        set[1] = (old == (limit & m));
        set[0] = (nw == 0);
        m_cnt = nw;
      end
      if (ctrl[11]) m_fl = '0;
      m_fl = m_fl | set;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp(input string req);
    logic [23:0] ec;
    ec = m_cnt & bmask(ctrl[9]);
    check(count_out == ec, req, count_out, ec);
    check(status_out == {5'd0, m_fl}, req, {16'd0, status_out}, {21'd0, m_fl});
  endtask

  // inputs already set at a negedge; advance one edge and compare
  task automatic step(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cmp(req);
  endtask

  task automatic pulses(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      pulse = 1; step(req);
      pulse = 0; step(req);
    end
  endtask

  task automatic qmove(input logic [1:0] ab, input string req);
    {qa, qb} = ab; step(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    @(negedge clk);
    step("R1"); step("R1");
    rst_n = 1;
    step("R1");
    check(count_out == 0 && status_out == 0, "R1", count_out, 0);

    // R5 single pulse up then down
    pulses(3, "R5");
    check(count_out == 24'd3, "R5", count_out, 24'd3);
    ctrl[12] = 1;
    pulses(1, "R5");
    check(count_out == 24'd2, "R5", count_out, 24'd2);
    // R10 reach zero
    pulses(2, "R10");
    check(status_out == 8'h01, "R10", {16'd0, status_out}, 24'h1);
    // R8 wrap down in 16-bit
    pulses(1, "R8");
    check(count_out == 24'h00FFFF, "R7", count_out, 24'h00FFFF);
    check(status_out[2] == 1'b1, "R8", {23'd0, status_out[2]}, 24'd1);
    // R11 soft clear keeps count
    ctrl[11] = 1; step("R11"); ctrl[11] = 0;
    check(status_out == 0 && count_out == 24'h00FFFF, "R11", count_out, 24'h00FFFF);
    // R11 collision: clear and wrap event together, flag survives
    ctrl[12] = 0; ctrl[11] = 1; pulse = 1; step("R11"); ctrl[11] = 0; pulse = 0; step("R11");
    check(status_out == 8'h05, "R11", {16'd0, status_out}, 24'h5);
    // R7 extended size: from 0 count up through 16-bit boundary
    ctrl[11] = 1; step("R11"); ctrl[11] = 0;
    ctrl[15] = 1; preset = 24'h00FFFE; step("R2"); ctrl[15] = 0; step("R2");
    ctrl[9] = 1;
    pulses(2, "R7");
    check(count_out == 24'h010000, "R7", count_out, 24'h010000);
    check(status_out[2] == 1'b0, "R7", {23'd0, status_out[2]}, 24'd0);
    // R9 limit
    limit = 24'h010001;
    pulses(1, "R9");
    check(status_out[1] == 1'b0, "R9", {23'd0, status_out[1]}, 24'd0);
    pulses(1, "R9");
    check(status_out[1] == 1'b1, "R9", {23'd0, status_out[1]}, 24'd1);
    // R2 preset held
    preset = 24'h123456; ctrl[15] = 1;
    pulses(3, "R2");
    check(count_out == 24'h123456, "R2", count_out, 24'h123456);
    ctrl[15] = 0; step("R2");
    pulses(1, "R2");
    check(count_out == 24'h123457, "R2", count_out, 24'h123457);
    // R3 clear beats preset and event
    ctrl[15] = 1; ctrl[14] = 1; pulse = 1; step("R3");
    ctrl[15] = 0; ctrl[14] = 0; pulse = 0; step("R3");
    check(count_out == 0 && status_out == 0, "R3", count_out, 0);
    // R4 gate
    ctrl[13] = 1; gate = 0;
    pulses(2, "R4");
    check(count_out == 0, "R4", count_out, 0);
    gate = 1; pulses(2, "R4");
    check(count_out == 24'd2, "R4", count_out, 24'd2);
    ctrl[13] = 0; gate = 0; pulses(1, "R4");
    check(count_out == 24'd3, "R4", count_out, 24'd3);
    // R6 quadrature forward, inverted, double step
    ctrl[8] = 1;
    qmove(2'b10, "R6"); qmove(2'b11, "R6"); qmove(2'b01, "R6"); qmove(2'b00, "R6");
    check(count_out == 24'd7, "R6", count_out, 24'd7);
    qmove(2'b11, "R6");
    check(count_out == 24'd7, "R6", count_out, 24'd7);
    qmove(2'b11, "R6");
    ctrl[12] = 1;
    qmove(2'b01, "R6"); qmove(2'b00, "R6");
    check(count_out == 24'd5, "R6", count_out, 24'd5);
    check(status_out[7:3] == 0, "R12", {19'd0, status_out[7:3]}, 0);

    // constrained random with collisions
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      ctrl = '0;
      ctrl[15] = (r[4:0] == 0);
      ctrl[14] = (r[10:5] == 0);
      ctrl[13] = r[11];
      ctrl[12] = r[12];
      ctrl[11] = (r[16:13] == 0);
      ctrl[9]  = (i / 500) % 2 == 1;
      ctrl[8]  = (i / 250) % 2 == 1;
      pulse = r[17]; qa = r[18]; qb = r[19]; gate = r[20] | r[21];
      if (r[27:22] == 0) limit = {16'd0, 8'($urandom)};
      if (r[31:28] == 0) preset = {16'd0, 8'($urandom)};
      step(i % 2 == 0 ? "R7" : "R12");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule